// File: doc/BRIEF.md
# Manchester Clock Acquisition Receiver

This block recovers bit timing and data from a Manchester-coded serial line that is sampled at a fixed multiple of the bit rate. The default is four samples per bit cell, for example a 40 MHz sample clock for a 10 Mb/s stream. A carrier detector elsewhere raises the receive enable. From then on, the block watches for falling mid-cell transitions, which mark Manchester zeros.

The first zero presets the internal cell phase. A second zero that arrives exactly two bit cells later restarts the phase counter and locks it. With the usual 1010 preamble, lock is therefore reached inside the first four bit cells. After lock, the block produces a gated receive clock whose rising edge marks the quarter point of each cell. It also produces a data output that presents each decoded bit one cell after that bit was strobed. A locked flag rises together with the first valid data bit.

Fine phase correction after lock belongs to a separate tracking block. This block holds its phase free-running once locked. Dropping the enable returns everything to idle.

Top module: `manch_clk_acq`

## Requirements
- R1: While reset is asserted, `rclk_o` is 0, `rx_data_o` is 1 and `locked_o` is 0.
- R2: Line encoding and lock rule. A Manchester zero is high in the first half of its cell and low in the second half. A one is low in the first half and high in the second half. Every high-to-low step of the sampled line counts as a candidate zero. The first candidate after enable presets the phase. Lock occurs on a candidate that falls exactly 2*OS samples after the previous candidate. Any other spacing makes the new candidate the preset point. If no candidate arrives within 2*OS samples, the search starts over.
- R3: With enable raised at the start of cell 1 and the preamble 1,0,1,0, lock is taken on the zero of cell 4.
- R4: Let L be the lock cell. From the quarter point of cell L+1 onward, `rclk_o` is high for OS/2 samples and low for OS/2 samples in every cell. Its rising edge is visible SYNC_STAGES+1 clock cycles after the quarter-point sample (sample index OS/4 of the cell) is presented on `line_i`. Before that point it stays 0.
- R5: The bit of cell c is the inverse of the line level at its quarter point. It appears on `rx_data_o` together with the `rclk_o` rising edge of cell c+1, and only for cells c ≥ L+1.
- R6: `rx_data_o` stays 1 from enable until the rising edge of cell L+1. Its value during cell L+1 is to be ignored.
- R7: `locked_o` rises together with the first valid data bit, at the quarter point of cell L+2. It then stays high while enable remains high.
- R8: One cycle after `rx_en_i` is sampled low, `rclk_o` is 0, `rx_data_o` is 1 and `locked_o` is 0. A later enable must acquire lock again from a new first zero.
- R9: Once locked, further falling steps on the line do not shift the phase. This includes the falls at the boundary between two ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock, OS times the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Sampled Manchester line level |
| rx_en_i | input | 1 | Receive enable from the carrier detector |
| rclk_o | output | 1 | Gated receive clock, rising at each cell's quarter point after lock |
| rx_data_o | output | 1 | Decoded receive data, idle high |
| locked_o | output | 1 | High from the first valid data bit until enable drops |

## Verification
Some properties are checked on every cycle. These are the idle values after a low enable, the even duty of the receive clock, the rule that data changes only on a clock rise or a disable, and the rule that the locked flag rises with the clock and then holds. Which cell lock lands on, and which bit appears on the data output in each cell, depend on the whole line history. Only the bench's sweeps show these. The sweeps cover every data pattern after a fixed preamble, every 10-bit line pattern with no preamble at all, and both idle line levels.

// File: rtl/mca_pkg.sv
package mca_pkg;
   typedef enum logic [1:0] {
      ACQ_WAIT = 2'd0,
      ACQ_SEEK = 2'd1,
      ACQ_LOCK = 2'd2
   } acq_state_e;
endpackage

// File: rtl/mca_line_sync.sv
module mca_line_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_i,
   output logic samp_o,
   output logic fall_o
);
   logic prev_q;

   if (SYNC_STAGES == 1) begin : g_single
      logic s_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) s_q <= 1'b0;
         else         s_q <= line_i;
      end
      assign samp_o = s_q;
   end else begin : g_chain
      logic [SYNC_STAGES-1:0] sh_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) sh_q <= '0;
         else         sh_q <= {sh_q[SYNC_STAGES-2:0], line_i};
      end
      assign samp_o = sh_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= samp_o;
   end

   assign fall_o = prev_q & ~samp_o;
endmodule

// File: rtl/mca_acq_seq.sv
module mca_acq_seq
   import mca_pkg::*;
#(
   parameter int OS = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic fall_i,
   output logic load_o,
   output logic lock_o
);
   localparam int GW = $clog2(2*OS + 1);
   localparam logic [GW-1:0] SPAN = GW'(2*OS);

   acq_state_e state_q, state_d;
   logic [GW-1:0] gap_q, gap_d;

   always_comb begin
      state_d = state_q;
      gap_d   = (gap_q == SPAN) ? gap_q : gap_q + 1'b1;
      load_o  = 1'b0;
      if (!en_i) begin
         state_d = ACQ_WAIT;
         gap_d   = '0;
      end else begin
         unique case (state_q)
            ACQ_WAIT: begin
               if (fall_i) begin
                  state_d = ACQ_SEEK;
                  gap_d   = GW'(1);
                  load_o  = 1'b1;
               end
            end
            ACQ_SEEK: begin
               if (fall_i) begin
                  load_o = 1'b1;
                  if (gap_q == SPAN) begin
                     state_d = ACQ_LOCK;
                  end else begin
                     gap_d = GW'(1);
                  end
               end else if (gap_q == SPAN) begin
                  state_d = ACQ_WAIT;
               end
            end
            ACQ_LOCK: state_d = ACQ_LOCK;
            default:  state_d = ACQ_WAIT;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ACQ_WAIT;
         gap_q   <= '0;
      end else begin
         state_q <= state_d;
         gap_q   <= gap_d;
      end
   end

   assign lock_o = (state_q == ACQ_LOCK);
endmodule

// File: rtl/mca_phase_ctr.sv
module mca_phase_ctr #(
   parameter int OS = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic load_i,
   output logic qtr_o,
   output logic win_o
);
   localparam int PW = $clog2(OS);
   localparam logic [PW-1:0] QTR     = PW'(OS/4);
   localparam logic [PW-1:0] WIN_END = PW'(OS/4 + OS/2);
   localparam logic [PW-1:0] PRESET  = PW'(OS/2 + 1);

   logic [PW-1:0] ph_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ph_q <= '0;
      else if (!en_i)   ph_q <= '0;
      else if (load_i)  ph_q <= PRESET;
      else              ph_q <= ph_q + 1'b1;
   end

   assign qtr_o = (ph_q == QTR);
   assign win_o = (ph_q >= QTR) && (ph_q < WIN_END);
endmodule

// File: rtl/mca_out_stage.sv
module mca_out_stage (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic lock_i,
   input  logic qtr_i,
   input  logic win_i,
   input  logic samp_i,
   output logic rclk_o,
   output logic data_o,
   output logic locked_o
);
   logic hold_q, primed_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rclk_o   <= 1'b0;
         data_o   <= 1'b1;
         hold_q   <= 1'b1;
         primed_q <= 1'b0;
         locked_o <= 1'b0;
      end else if (!en_i) begin
         rclk_o   <= 1'b0;
         data_o   <= 1'b1;
         hold_q   <= 1'b1;
         primed_q <= 1'b0;
         locked_o <= 1'b0;
      end else begin
         rclk_o <= lock_i && win_i;
         if (lock_i && qtr_i) begin
            data_o   <= hold_q;
            hold_q   <= ~samp_i;
            primed_q <= 1'b1;
            if (primed_q) locked_o <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/manch_clk_acq.sv
module manch_clk_acq #(
   parameter int OS          = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_i,
   input  logic rx_en_i,
   output logic rclk_o,
   output logic rx_data_o,
   output logic locked_o
);
   initial begin
      if (OS < 4 || (OS & (OS - 1)) != 0)
         $fatal(1, "OS must be a power of two of at least 4");
      if (SYNC_STAGES < 1)
         $fatal(1, "SYNC_STAGES must be at least 1");
   end

   logic samp, fall, load, lock, qtr, win;

   mca_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_i),
      .samp_o(samp), .fall_o(fall)
   );

   mca_acq_seq #(.OS(OS)) u_seq (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rx_en_i), .fall_i(fall),
      .load_o(load), .lock_o(lock)
   );

   mca_phase_ctr #(.OS(OS)) u_phase (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rx_en_i), .load_i(load),
      .qtr_o(qtr), .win_o(win)
   );

   mca_out_stage u_out (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rx_en_i), .lock_i(lock),
      .qtr_i(qtr), .win_i(win), .samp_i(samp),
      .rclk_o(rclk_o), .data_o(rx_data_o), .locked_o(locked_o)
   );
endmodule

// File: rtl/manch_clk_acq_chk.sv
module mca_checker (
   input logic clk_i,
   input logic rst_ni,
   input logic rx_en_i,
   input logic rclk_o,
   input logic rx_data_o,
   input logic locked_o
);
   AST_IDLE_AFTER_DISABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(rx_en_i) |-> (!rclk_o && rx_data_o && !locked_o)); // R8
   AST_RCLK_HIGH_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rclk_o) && rx_en_i |=> rclk_o); // R4
   AST_RCLK_LOW_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rclk_o) && rx_en_i |=> !rclk_o); // R4
   AST_DATA_ON_RCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(rx_data_o) |-> ($rose(rclk_o) || !$past(rx_en_i))); // R5
   AST_LOCK_WITH_RCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(locked_o) |-> $rose(rclk_o)); // R7
   AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      locked_o && rx_en_i |=> locked_o); // R7
endmodule

bind manch_clk_acq mca_checker u_mca_checker (
   .clk_i(clk_i), .rst_ni(rst_ni), .rx_en_i(rx_en_i),
   .rclk_o(rclk_o), .rx_data_o(rx_data_o), .locked_o(locked_o)
);

// File: tb/manch_clk_acq_bench.sv
`timescale 1ns/100ps
module manch_clk_acq_bench;
   localparam int OS   = 4;
   localparam int SYNC = 2;
   localparam int QTR  = OS/4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line = 1'b0;
   logic en = 1'b0;
   logic rclk, rxd, lck;
   int tests = 0;
   int fails = 0;
   bit done = 1'b0;
   logic fb [1:16];

   always #2.5 clk = ~clk;

   manch_clk_acq #(.OS(OS), .SYNC_STAGES(SYNC)) u_manch_clk_acq (
      .clk_i(clk), .rst_ni(rst_n), .line_i(line), .rx_en_i(en),
      .rclk_o(rclk), .rx_data_o(rxd), .locked_o(lck)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
      end
   endtask

   // Plays one frame of ncell bits from fb, enable high from cell 1, then idle.
   task automatic run_frame(input int ncell, input logic idle_lvl,
                            input string tclk, input string tdat, input string tlck);
      int lc = 0;
      int last = ncell * OS;
      for (int c = 3; c <= ncell; c++)
         if (lc == 0 && fb[c-2] == 1'b0 && fb[c-1] == 1'b1 && fb[c] == 1'b0) lc = c;
      for (int k = 0; k <= last + 2*OS; k++) begin
         @(negedge clk);
         if (k <= last) begin
            int kk = k - 1 - SYNC - QTR;
            logic e_clk = 1'b0;
            logic e_dat = 1'b1;
            logic e_lck = 1'b0;
            bit dat_ok = 1'b1;
            if (kk >= 0 && lc != 0) begin
               int cc = kk / OS + 1;
               int r  = kk % OS;
               if (cc >= lc + 1) e_clk = (r < OS/2);
               if (cc == lc + 1) dat_ok = 1'b0;
               if (cc >= lc + 2) begin
                  e_dat = fb[cc-1];
                  e_lck = 1'b1;
               end
            end
            chk(tclk, "rclk", rclk, e_clk);
            chk(tlck, "locked", lck, e_lck);
            if (dat_ok) chk(e_lck ? tdat : "R6", "rx_data", rxd, e_dat);
         end else begin
            chk("R8", "rclk idle", rclk, 1'b0);
            chk("R8", "rx_data idle", rxd, 1'b1);
            chk("R8", "locked idle", lck, 1'b0);
         end
         if (k < last) begin
            en = 1'b1;
            line = ((k % OS) < OS/2) ? ~fb[k/OS + 1] : fb[k/OS + 1];
         end else begin
            en = 1'b0;
            line = idle_lvl;
         end
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk("R1", "rclk in reset", rclk, 1'b0);
      chk("R1", "rx_data in reset", rxd, 1'b1);
      chk("R1", "locked in reset", lck, 1'b0);
      rst_n = 1'b1;
      repeat (2*OS) @(negedge clk);
      // Fixed 1010 preamble, one, then every 6-bit data pattern.
      for (int p = 0; p < 64; p++) begin
         fb[1] = 1'b1; fb[2] = 1'b0; fb[3] = 1'b1; fb[4] = 1'b0; fb[5] = 1'b1;
         for (int i = 0; i < 6; i++) fb[6+i] = p[i];
         fb[12] = 1'b1;
         run_frame(12, p[0], "R3 R4 R9", "R5 R9", "R3 R7");
      end
      // Every 10-bit line pattern, no preamble imposed.
      for (int p = 0; p < 1024; p++) begin
         for (int i = 0; i < 10; i++) fb[1+i] = p[i];
         run_frame(10, p[2] ^ p[5], "R2 R4", "R2 R5", "R2 R7");
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule